// File: doc/BRIEF.md
# Over/Undervoltage Duty-Cycle Regulator

This block steers an 8-bit PWM duty counter from two comparator flags, one for overvoltage and one for undervoltage. While neither flag is raised, the duty counter is frozen. At reset it starts at the midpoint value of 128, which is 50% duty. An overvoltage flag makes the counter step down by one every clock, so the duty cycle falls. An undervoltage flag makes it step up by one every clock, so the duty cycle rises. Each time the block enters one of these two correction modes, it reloads the counter to the midpoint, so every correction starts again from 50%.

The duty counter wraps around when it reaches an end value, and a wrap would throw the duty cycle from one extreme to the other. Two guard counters stop this from happening. The overvoltage guard is preset three counts below the midpoint and the undervoltage guard three counts above it. Each guard moves in step with the duty counter, so it reaches its terminal value before the duty counter reaches its own end. The guard's terminal pulse is caught in a latch, and the latch freezes the duty counter.

The block exposes the reset, hold and direction controls it applies to the duty counter. It also exposes the duty value, so that a PWM stage can use it and a bench can observe it. The block models the duty counter and both guards internally.

Top module: `ovuv_duty_regulator`

## Requirements
- R1: Out of reset, duty_o is 128, ctr_hold_o is 1, and ctr_up_o and ctr_rst_o are 0.
- R2: While overvoltage is active and not clamped, ctr_hold_o and ctr_up_o are 0 and duty_o falls by exactly 1 per clock.
- R3: While undervoltage is active and not clamped, ctr_hold_o is 0, ctr_up_o is 1 and duty_o rises by exactly 1 per clock.
- R4: Each flag passes through two synchronising flip-flops. A flag change made between two edges drives ctr_rst_o high after the second following edge. The third edge then applies the mode change to duty_o.
- R5: In overvoltage mode, the guard preset to 125 clamps the duty. duty_o settles at 2 and ctr_hold_o goes to 1.
- R6: In undervoltage mode, the guard preset to 131 clamps the duty. duty_o settles at 253, ctr_hold_o goes to 1 and ctr_up_o stays 1.
- R7: Any entry into overvoltage or undervoltage mode, from hold or from the opposite mode, raises ctr_rst_o for one cycle. It also reloads duty_o to 128 on the next edge.
- R8: When both flags are clear, the block returns to hold: ctr_hold_o is 1, ctr_up_o is 0, duty_o keeps its value and the clamp latch is released.
- R9: When both flags are raised together, overvoltage wins and duty_o counts down.
- R10: duty_o never reaches 0 or 255, so the duty counter never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ov_flag_i | input | 1 | Overvoltage comparator flag, asynchronous |
| uv_flag_i | input | 1 | Undervoltage comparator flag, asynchronous |
| ctr_rst_o | output | 1 | Reload pulse to the duty counter on mode entry |
| ctr_hold_o | output | 1 | Freeze control to the duty counter |
| ctr_up_o | output | 1 | Count direction to the duty counter, 1 = up |
| duty_o | output | 8 | Current duty value, in 256ths of a period |

## Verification
A guard counter that slips against the duty counter shows up at the ports as a wrong clamp value. The effect appears within about 130 cycles of entering a mode: duty_o settles somewhere other than 2 or 253, or it wraps to the far end. A wrong mode register or a latch that fails to clear shows up within three clocks of a flag change. The symptom is a wrong level on ctr_hold_o or ctr_up_o, a missing reload to 128, or a duty value that drifts while the block is in hold.

// File: rtl/ovuv_pkg.sv
package ovuv_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_OV   = 2'd1,
    MODE_UV   = 2'd2
  } reg_mode_e;
endpackage

// File: rtl/ovuv_flag_sync.sv
module ovuv_flag_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ovuv_step_counter.sv
module ovuv_step_counter #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned INIT  = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             keep_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] LOAD_VAL = WIDTH'(INIT);
  localparam logic [WIDTH-1:0] TOP_VAL  = '1;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign term_o = up_i ? (cnt_q == TOP_VAL) : (cnt_q == '0);
  assign cnt_en = clr_i | ~keep_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || term_o) begin
      cnt_d = LOAD_VAL;
    end else if (up_i) begin
      cnt_d = cnt_q + WIDTH'(1);
    end else begin
      cnt_d = cnt_q - WIDTH'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || (term_o && !keep_i)) |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/ovuv_duty_regulator.sv
module ovuv_duty_regulator
  import ovuv_pkg::*;
#(
  parameter int unsigned DUTY_W       = 8,
  parameter int unsigned MAIN_INIT    = 128,
  parameter int unsigned GUARD_MARGIN = 3,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ov_flag_i,
  input  logic              uv_flag_i,
  output logic              ctr_rst_o,
  output logic              ctr_hold_o,
  output logic              ctr_up_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int unsigned OV_GUARD_INIT = MAIN_INIT - GUARD_MARGIN;
  localparam int unsigned UV_GUARD_INIT = MAIN_INIT + GUARD_MARGIN;

  logic [1:0]  flags_s;
  logic        ov_s, uv_s;
  reg_mode_e   mode_q, mode_d, mode_req;
  logic        clamp_q, clamp_d;
  logic        mode_change, enter_ov, enter_uv;
  logic        ov_guard_hold, uv_guard_hold;
  logic        ov_guard_term, uv_guard_term;
  logic [DUTY_W-1:0] ov_guard_cnt, uv_guard_cnt;

  ovuv_flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({uv_flag_i, ov_flag_i}),
    .sync_o  (flags_s)
  );
  assign ov_s = flags_s[0];
  assign uv_s = flags_s[1];

  // Requested mode: overvoltage has priority
  always_comb begin
    if (ov_s)      mode_req = MODE_OV;
    else if (uv_s) mode_req = MODE_UV;
    else           mode_req = MODE_HOLD;
  end

  assign mode_change = (mode_req != mode_q);
  assign enter_ov    = mode_change && (mode_req == MODE_OV);
  assign enter_uv    = mode_change && (mode_req == MODE_UV);

  always_comb begin
    mode_d  = mode_req;
    clamp_d = clamp_q;
    if (mode_change) begin
      clamp_d = 1'b0;
    end else if ((mode_q == MODE_OV && ov_guard_term && !ov_guard_hold) ||
                 (mode_q == MODE_UV && uv_guard_term && !uv_guard_hold)) begin
      clamp_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_HOLD;
      clamp_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      clamp_q <= clamp_d;
    end
  end

  assign ctr_rst_o  = enter_ov | enter_uv;
  assign ctr_hold_o = (mode_q == MODE_HOLD) | clamp_q;
  assign ctr_up_o   = (mode_q == MODE_UV);

  assign ov_guard_hold = (mode_q != MODE_OV) | clamp_q;
  assign uv_guard_hold = (mode_q != MODE_UV) | clamp_q;

  ovuv_step_counter #(.WIDTH(DUTY_W), .INIT(MAIN_INIT)) main_cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_rst_o),
    .keep_i (ctr_hold_o),
    .up_i   (ctr_up_o),
    .cnt_o  (duty_o),
    .term_o ()
  );

  ovuv_step_counter #(.WIDTH(DUTY_W), .INIT(OV_GUARD_INIT)) ov_guard_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (enter_ov),
    .keep_i (ov_guard_hold),
    .up_i   (1'b0),
    .cnt_o  (ov_guard_cnt),
    .term_o (ov_guard_term)
  );

  ovuv_step_counter #(.WIDTH(DUTY_W), .INIT(UV_GUARD_INIT)) uv_guard_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (enter_uv),
    .keep_i (uv_guard_hold),
    .up_i   (1'b1),
    .cnt_o  (uv_guard_cnt),
    .term_o (uv_guard_term)
  );

  // R2
  ov_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OV && !ctr_hold_o && !ctr_rst_o)
      |=> (duty_o == $past(duty_o) - DUTY_W'(1)));

  // R3
  uv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_UV && !ctr_hold_o && !ctr_rst_o)
      |=> (duty_o == $past(duty_o) + DUTY_W'(1)));

  // R8
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_hold_o && !ctr_rst_o) |=> $stable(duty_o));

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_rst_o |=> (duty_o == DUTY_W'(MAIN_INIT)) && !ctr_rst_o);

  // R10
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o != '0) && (duty_o != '1));

  // R9
  ov_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_s && uv_s && !ctr_rst_o) |-> !ctr_up_o);
endmodule

// File: tb/ovuv_duty_regulator_tb_top.sv
module ovuv_duty_regulator_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        ov;
    logic        uv;
    logic [15:0] waits;
    logic [7:0]  duty;
    logic        hold;
    logic        up;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 16'd13,  8'd118, 1'b0, 1'b0, 8'd2},  // R2 counting down
    '{1'b1, 1'b0, 16'd200, 8'd2,   1'b1, 1'b0, 8'd5},  // R5 low clamp
    '{1'b0, 1'b0, 16'd5,   8'd2,   1'b1, 1'b0, 8'd8},  // R8 back to hold
    '{1'b0, 1'b1, 16'd3,   8'd128, 1'b0, 1'b1, 8'd7},  // R7 restart from hold
    '{1'b0, 1'b1, 16'd10,  8'd138, 1'b0, 1'b1, 8'd3},  // R3 counting up
    '{1'b0, 1'b1, 16'd200, 8'd253, 1'b1, 1'b1, 8'd6},  // R6 high clamp
    '{1'b0, 1'b0, 16'd5,   8'd253, 1'b1, 1'b0, 8'd8},  // R8 back to hold
    '{1'b1, 1'b1, 16'd13,  8'd118, 1'b0, 1'b0, 8'd9},  // R9 both flags
    '{1'b0, 1'b1, 16'd3,   8'd128, 1'b0, 1'b1, 8'd7},  // R7 opposite mode
    '{1'b0, 1'b1, 16'd5,   8'd133, 1'b0, 1'b1, 8'd3},  // R3
    '{1'b0, 1'b0, 16'd3,   8'd136, 1'b1, 1'b0, 8'd4}   // R4 latency of clear
  };

  logic       clk, rst_n, ov, uv;
  logic       c_rst, c_hold, c_up;
  logic [7:0] duty;
  int         n_checks = 0;
  int         n_fail   = 0;
  int         wrap_seen = 0;

  ovuv_duty_regulator dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ov_flag_i  (ov),
    .uv_flag_i  (uv),
    .ctr_rst_o  (c_rst),
    .ctr_hold_o (c_hold),
    .ctr_up_o   (c_up),
    .duty_o     (duty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && (duty == 8'd0 || duty == 8'd255)) wrap_seen++;
  end

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ov = 1'b0; uv = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    chk("R1", "duty", duty, 128);
    chk("R1", "hold", c_hold, 1);
    chk("R1", "up",   c_up, 0);
    chk("R1", "rst",  c_rst, 0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[v].req);
      ov = VECS[v].ov;
      uv = VECS[v].uv;
      wait_neg(int'(VECS[v].waits));
      chk(tag, "duty", duty, int'(VECS[v].duty));
      chk(tag, "hold", c_hold, int'(VECS[v].hold));
      chk(tag, "up",   c_up, int'(VECS[v].up));
    end

    // R4: reload pulse two edges after the flag, duty reload on the third
    ov = 1'b1;
    wait_neg(1);
    chk("R4", "rst after 1 edge", c_rst, 0);
    wait_neg(1);
    chk("R4", "rst after 2 edges", c_rst, 1);
    chk("R4", "duty before reload", duty, 136);
    wait_neg(1);
    chk("R4", "duty after reload", duty, 128);
    chk("R7", "single-cycle rst", c_rst, 0);

    // R2: one more step down
    wait_neg(1);
    chk("R2", "duty step", duty, 127);

    // R10: no wrap in any cycle of the run
    chk("R10", "wrap cycles", wrap_seen, 0);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    wait_neg(1);
    chk("R1", "duty in reset", duty, 128);
    chk("R1", "hold in reset", c_hold, 1);
    ov = 1'b0;
    rst_n = 1'b1;
    wait_neg(3);
    chk("R1", "duty after reset", duty, 128);
    chk("R8", "hold after reset", c_hold, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule